// File: doc/BRIEF.md
# Low-Order Path Overhead Status Capture

This block holds two low-order path overhead values for a processor to read. Once per multiframe, a strobe arrives with the received V5 byte, and the block stores that raw byte as the V5 status value. The status value changes at multiframe rate, every 500 microseconds. It does not raise an alarm or an interrupt. The block also keeps a small Enhanced RDI status value taken from the K4 byte. That value changes only when the RDI bit carried in V5 changes state and the tributary source is configured to support Enhanced RDI. A new K4 byte on its own does not change it.

K4 bytes arrive at any point in the multiframe with their own valid strobe. The block keeps the Enhanced RDI bits of the latest one. When a qualifying RDI change is seen at a multiframe strobe, those bits are copied into the K4 status value. The processor reads both values through a simple registered read port. Write cycles on that port are accepted and have no effect. The asynchronous active-low reset is released in step with the clock inside the block.

Top module: `ohc_status_capture`

## Requirements
- R1: When `mf_stb` is high at a clock edge, `v5_stat` shows the `v5_byte` sampled at that edge, starting from the following cycle.
- R2: While `mf_stb` is low, `v5_stat` keeps its value, whatever `v5_byte` carries.
- R3: The RDI bit is bit 0 of the V5 byte. The reference for detecting a change is the RDI bit of the last stored V5 byte, which is 0 after reset.
- R4: In `k4_stat`, bits 3:1 carry the three Enhanced RDI bits, and bits 7:4 and bit 0 always read as zero.
- R5: `k4_stat` changes only at an edge where `mf_stb` and `erdi_en` are both high and bit 0 of `v5_byte` differs from the stored RDI bit.
- R6: On such an update, the Enhanced RDI bits come from `k4_erdi` if `k4_vld` is high in the same cycle. Otherwise they come from the most recent `k4_erdi` accepted with `k4_vld` (zero after reset).
- R7: Reset clears `v5_stat`, `k4_stat`, `bus_rdata` and the held Enhanced RDI bits to zero, asynchronously.
- R8: A cycle with `bus_rd` high and `bus_wr` low loads `bus_rdata` with the selected register (`bus_sel` 0 = V5 status, 1 = K4 status), valid from the next cycle. If an update happens at the same edge, the value loaded is the one held before the update.
- R9: `bus_wr` never changes `v5_stat` or `k4_stat`. A cycle with `bus_wr` high does not load `bus_rdata`, and `bus_rdata` holds its value in every cycle that is not a read.
- R10: With `erdi_en` low, a multiframe strobe still updates the stored RDI bit, but `k4_stat` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mf_stb | input | 1 | Multiframe strobe, qualifies `v5_byte` |
| v5_byte | input | 8 | Received V5 byte |
| k4_vld | input | 1 | K4 byte valid strobe |
| k4_erdi | input | 3 | Enhanced RDI bits of the received K4 byte |
| erdi_en | input | 1 | Tributary source supports Enhanced RDI |
| bus_rd | input | 1 | Processor read strobe |
| bus_wr | input | 1 | Processor write strobe (ignored by the registers) |
| bus_sel | input | 1 | Register select: 0 V5 status, 1 K4 status |
| bus_rdata | output | 8 | Registered read data |
| v5_stat | output | 8 | V5 status register |
| k4_stat | output | 8 | K4 Enhanced RDI status register |

## Verification
On every cycle the assertions check the following: the V5 capture and hold, the zero bits in the K4 status format, that the K4 status stays unchanged unless a qualifying RDI change occurs, the copy of same-cycle Enhanced RDI bits on an update, and the behaviour of the read port when it is loaded and when it holds. The bench scenarios cover what needs history across several multiframes. These are the RDI reference still being tracked while support is disabled, the use of K4 bits held from earlier multiframes, a read that meets an update at the same edge, and the RDI reference returning to zero after a reset in mid-operation.

// File: rtl/ohc_pkg.sv
package ohc_pkg;
  // Byte width of the overhead values and the read bus
  localparam int unsigned BYTE_W   = 8;
  // Enhanced RDI field width and its position in the K4 status byte
  localparam int unsigned ERDI_W   = 3;
  localparam int unsigned ERDI_LSB = 1;
  // Number of processor-readable registers
  localparam int unsigned NREG     = 2;

  typedef logic [BYTE_W-1:0] ohc_byte_t;
endpackage

// File: rtl/ohc_rst_sync.sv
module ohc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ohc_v5_capture.sv
module ohc_v5_capture #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned RDI_POS = 0
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              mf_stb,
  input  logic [BYTE_W-1:0] v5_in,
  output logic [BYTE_W-1:0] v5_stat,
  output logic              rdi_chg
);
  logic [BYTE_W-1:0] v5_q;
  logic [BYTE_W-1:0] v5_d;
  logic              v5_ce;

  // The stored byte doubles as the RDI reference for change detection
  always_comb begin
    v5_ce   = mf_stb;
    v5_d    = v5_ce ? v5_in : v5_q;
    rdi_chg = v5_ce && (v5_in[RDI_POS] != v5_q[RDI_POS]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      v5_q <= '0;
    end else begin
      v5_q <= v5_d;
    end
  end

  assign v5_stat = v5_q;
endmodule

// File: rtl/ohc_erdi_track.sv
module ohc_erdi_track #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ERDI_W   = 3,
  parameter int unsigned ERDI_LSB = 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              k4_vld,
  input  logic [ERDI_W-1:0] k4_erdi,
  input  logic              erdi_en,
  input  logic              rdi_chg,
  output logic [BYTE_W-1:0] k4_stat
);
  logic [ERDI_W-1:0] hold_q;
  logic [ERDI_W-1:0] hold_d;
  logic [ERDI_W-1:0] stat_q;
  logic [ERDI_W-1:0] stat_d;
  logic [ERDI_W-1:0] erdi_src;
  logic              stat_ce;

  always_comb begin
    erdi_src = k4_vld ? k4_erdi : hold_q;
    hold_d   = erdi_src;
    stat_ce  = rdi_chg && erdi_en;
    stat_d   = stat_ce ? erdi_src : stat_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hold_q <= '0;
      stat_q <= '0;
    end else begin
      hold_q <= hold_d;
      stat_q <= stat_d;
    end
  end

  // Only the field is stored; the rest of the byte is constant zero
  always_comb begin
    k4_stat = '0;
    k4_stat[ERDI_LSB +: ERDI_W] = stat_q;
  end
endmodule

// File: rtl/ohc_rd_port.sv
module ohc_rd_port #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NREG   = 2,
  localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        clk,
  input  logic                        srst_n,
  input  logic                        rd,
  input  logic                        wr,
  input  logic [SEL_W-1:0]            sel,
  input  logic [NREG-1:0][BYTE_W-1:0] regs,
  output logic [BYTE_W-1:0]           rdata
);
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] rdata_d;
  logic              rd_ce;

  always_comb begin
    rd_ce   = rd && !wr;
    rdata_d = rd_ce ? regs[sel] : rdata_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ohc_status_capture.sv
module ohc_status_capture #(
  parameter int unsigned BYTE_W      = ohc_pkg::BYTE_W,
  parameter int unsigned ERDI_W      = ohc_pkg::ERDI_W,
  parameter int unsigned ERDI_LSB    = ohc_pkg::ERDI_LSB,
  parameter int unsigned RDI_POS     = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mf_stb,
  input  logic [BYTE_W-1:0] v5_byte,
  input  logic              k4_vld,
  input  logic [ERDI_W-1:0] k4_erdi,
  input  logic              erdi_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_sel,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] v5_stat,
  output logic [BYTE_W-1:0] k4_stat
);
  localparam int unsigned NREG   = ohc_pkg::NREG;
  localparam int unsigned IDX_V5 = 0;
  localparam int unsigned IDX_K4 = 1;

  logic                        srst_n;
  logic                        rdi_chg;
  logic [NREG-1:0][BYTE_W-1:0] rd_regs;

  ohc_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) rst_sync_i (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  ohc_v5_capture #(
    .BYTE_W (BYTE_W),
    .RDI_POS(RDI_POS)
  ) v5_cap_i (
    .clk    (clk),
    .srst_n (srst_n),
    .mf_stb (mf_stb),
    .v5_in  (v5_byte),
    .v5_stat(v5_stat),
    .rdi_chg(rdi_chg)
  );

  ohc_erdi_track #(
    .BYTE_W  (BYTE_W),
    .ERDI_W  (ERDI_W),
    .ERDI_LSB(ERDI_LSB)
  ) erdi_i (
    .clk    (clk),
    .srst_n (srst_n),
    .k4_vld (k4_vld),
    .k4_erdi(k4_erdi),
    .erdi_en(erdi_en),
    .rdi_chg(rdi_chg),
    .k4_stat(k4_stat)
  );

  always_comb begin
    rd_regs         = '0;
    rd_regs[IDX_V5] = v5_stat;
    rd_regs[IDX_K4] = k4_stat;
  end

  ohc_rd_port #(
    .BYTE_W(BYTE_W),
    .NREG  (NREG)
  ) rd_i (
    .clk   (clk),
    .srst_n(srst_n),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .sel   (bus_sel),
    .regs  (rd_regs),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/ohc_status_capture_chk.sv
module ohc_status_capture_chk #(
  parameter int unsigned BYTE_W   = ohc_pkg::BYTE_W,
  parameter int unsigned ERDI_W   = ohc_pkg::ERDI_W,
  parameter int unsigned ERDI_LSB = ohc_pkg::ERDI_LSB,
  parameter int unsigned RDI_POS  = 0
) (
  input logic              clk,
  input logic              srst_n,
  input logic              mf_stb,
  input logic [BYTE_W-1:0] v5_byte,
  input logic              k4_vld,
  input logic [ERDI_W-1:0] k4_erdi,
  input logic              erdi_en,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_sel,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [BYTE_W-1:0] v5_stat,
  input logic [BYTE_W-1:0] k4_stat
);
  localparam logic [BYTE_W-1:0] FIELD_MASK =
    BYTE_W'(((1 << ERDI_W) - 1) << ERDI_LSB);

  logic qual_chg;
  logic rd_cyc;
  assign qual_chg = mf_stb && erdi_en && (v5_byte[RDI_POS] != v5_stat[RDI_POS]);
  assign rd_cyc   = bus_rd && !bus_wr;

  assert_v5_capture_R1: assert property (@(posedge clk) disable iff (!srst_n)
    mf_stb |=> (v5_stat == $past(v5_byte)));

  assert_v5_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !mf_stb |=> $stable(v5_stat));

  assert_k4_format_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (k4_stat & ~FIELD_MASK) == '0);

  assert_k4_only_on_change_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !qual_chg |=> $stable(k4_stat));

  assert_k4_same_cycle_src_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (qual_chg && k4_vld) |=> (k4_stat[ERDI_LSB +: ERDI_W] == $past(k4_erdi)));

  assert_rd_load_v5_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_cyc && !bus_sel) |=> (bus_rdata == $past(v5_stat)));

  assert_rd_load_k4_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_cyc && bus_sel) |=> (bus_rdata == $past(k4_stat)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_cyc |=> $stable(bus_rdata));
endmodule

bind ohc_status_capture ohc_status_capture_chk chk_i (
  .clk      (clk),
  .srst_n   (srst_n),
  .mf_stb   (mf_stb),
  .v5_byte  (v5_byte),
  .k4_vld   (k4_vld),
  .k4_erdi  (k4_erdi),
  .erdi_en  (erdi_en),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_sel  (bus_sel),
  .bus_rdata(bus_rdata),
  .v5_stat  (v5_stat),
  .k4_stat  (k4_stat)
);

// File: tb/ohc_status_capture_tb.sv
module ohc_status_capture_tb_top;
  logic       clk;
  logic       rst_n;
  logic       mf_stb;
  logic [7:0] v5_byte;
  logic       k4_vld;
  logic [2:0] k4_erdi;
  logic       erdi_en;
  logic       bus_rd;
  logic       bus_wr;
  logic       bus_sel;
  logic [7:0] bus_rdata;
  logic [7:0] v5_stat;
  logic [7:0] k4_stat;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  ohc_status_capture dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mf_stb   (mf_stb),
    .v5_byte  (v5_byte),
    .k4_vld   (k4_vld),
    .k4_erdi  (k4_erdi),
    .erdi_en  (erdi_en),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_sel  (bus_sel),
    .bus_rdata(bus_rdata),
    .v5_stat  (v5_stat),
    .k4_stat  (k4_stat)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: mf[29] v5[28:21] kv[20] k4[19:17] en[16] exp_v5[15:8] exp_k4[7:0]
  // The expected K4 status places the field in bits 3:1 (R4).
  localparam int NVEC = 11;
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b1, 3'b101, 1'b1, 8'h00, 8'h00}, // K4 held only
    {1'b1, 8'h01, 1'b0, 3'b000, 1'b1, 8'h01, 8'h0A}, // RDI 0->1, held bits
    {1'b1, 8'h35, 1'b1, 3'b011, 1'b1, 8'h35, 8'h0A}, // RDI steady
    {1'b1, 8'h20, 1'b1, 3'b110, 1'b1, 8'h20, 8'h0C}, // RDI 1->0, same-cycle K4
    {1'b1, 8'h41, 1'b0, 3'b000, 1'b0, 8'h41, 8'h0C}, // change while disabled (R10)
    {1'b1, 8'hC3, 1'b0, 3'b000, 1'b1, 8'hC3, 8'h0C}, // reference already 1 (R10)
    {1'b0, 8'hFF, 1'b1, 3'b111, 1'b1, 8'hC3, 8'h0C}, // no strobe, V5 ignored
    {1'b1, 8'h02, 1'b0, 3'b000, 1'b1, 8'h02, 8'h0E}, // RDI 1->0
    {1'b0, 8'h55, 1'b0, 3'b000, 1'b1, 8'h02, 8'h0E}, // no strobe
    {1'b1, 8'hFE, 1'b1, 3'b000, 1'b1, 8'hFE, 8'h0E}, // RDI steady, K4 zero held
    {1'b1, 8'hFF, 1'b0, 3'b000, 1'b1, 8'hFF, 8'h00}  // RDI 0->1, zero field
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mf_stb  = 1'b0;
    v5_byte = 8'h00;
    k4_vld  = 1'b0;
    k4_erdi = 3'b000;
    erdi_en = 1'b1;
    bus_rd  = 1'b0;
    bus_wr  = 1'b0;
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset values
    check("R7 v5_stat after reset", v5_stat, 8'h00);
    check("R7 k4_stat after reset", k4_stat, 8'h00);
    check("R7 bus_rdata after reset", bus_rdata, 8'h00);

    // Table walk: R1 R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      mf_stb  = VEC[i][29];
      v5_byte = VEC[i][28:21];
      k4_vld  = VEC[i][20];
      k4_erdi = VEC[i][19:17];
      erdi_en = VEC[i][16];
      @(negedge clk);
      check($sformatf("R1 R2 v5_stat vec %0d", i), v5_stat, VEC[i][15:8]);
      check($sformatf("R4 R5 R6 R10 k4_stat vec %0d", i), k4_stat, VEC[i][7:0]);
    end
    idle_inputs();

    // R8: reads of each register (v5=FF, k4=00)
    bus_rd = 1'b1; bus_sel = 1'b0;
    @(negedge clk);
    check("R8 read V5 status", bus_rdata, 8'hFF);
    bus_sel = 1'b1;
    @(negedge clk);
    check("R8 read K4 status", bus_rdata, 8'h00);

    // R8: read meets update at the same edge, old value returned
    bus_sel = 1'b0;
    mf_stb = 1'b1; v5_byte = 8'h00; k4_vld = 1'b1; k4_erdi = 3'b101;
    @(negedge clk);
    check("R8 same-edge read gives old V5", bus_rdata, 8'hFF);
    check("R1 V5 updated alongside read", v5_stat, 8'h00);
    check("R6 K4 updated alongside read", k4_stat, 8'h0A);
    mf_stb = 1'b0; k4_vld = 1'b0;
    @(negedge clk);
    check("R8 next read gives new V5", bus_rdata, 8'h00);
    bus_sel = 1'b1;
    @(negedge clk);
    check("R8 read K4 after update", bus_rdata, 8'h0A);

    // R9: write cycles change nothing
    bus_sel = 1'b0; bus_wr = 1'b1;
    @(negedge clk);
    check("R9 write does not load rdata", bus_rdata, 8'h0A);
    check("R9 write leaves V5 status", v5_stat, 8'h00);
    check("R9 write leaves K4 status", k4_stat, 8'h0A);
    bus_sel = 1'b1;
    @(negedge clk);
    check("R9 write to K4 slot ignored", k4_stat, 8'h0A);
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    check("R9 rdata holds when idle", bus_rdata, 8'h0A);

    // R7: asynchronous reset in mid-operation
    rst_n = 1'b0;
    #1;
    check("R7 async clear K4 status", k4_stat, 8'h00);
    check("R7 async clear rdata", bus_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 V5 status after second reset", v5_stat, 8'h00);

    // R3: RDI reference is 0 after reset, RDI is bit 0
    mf_stb = 1'b1; v5_byte = 8'hFE; k4_vld = 1'b1; k4_erdi = 3'b111;
    @(negedge clk);
    check("R3 bit0 steady at 0, no K4 update", k4_stat, 8'h00);
    v5_byte = 8'h01; k4_vld = 1'b0;
    @(negedge clk);
    check("R3 bit0 rises, K4 updated from held bits", k4_stat, 8'h0E);
    idle_inputs();
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule